// File: doc/BRIEF.md
# Per-Channel Window Watchdog for Conversion Results

This block watches the stream of conversion results leaving a multi-channel converter. Each result arrives with a valid strobe, a 10-bit value and a 4-bit channel number. When the channel is enabled in a 16-bit mask, the value is tested against a programmable upper bound and a programmable lower bound. A value at or beyond either bound is an event. An event sets a global flag and the sticky status bit of that channel, and an interrupt follows when it is enabled.

Configuration comes through a byte-wide register write port. Each bound is 10 bits wide and is written in two parts. The upper two bits are staged first, and the bound changes only when the low byte is written. Status bits and the global flag stay set until software writes a zero to them. An event that falls in the same cycle as a clear is kept.

Top module: `win_wdg_top`

## Requirements
- R1: After reset, flag_o, status_o and irq_o are all zero. The channel mask is all zero and the interrupt enable is off. The upper bound resets to 1023 and the lower bound to 0.
- R2: A valid result on an enabled channel whose value is greater than or equal to the upper bound sets flag_o and status_o[channel] at the next rising clock edge. Equality counts as an event.
- R3: A valid result on an enabled channel whose value is less than or equal to the lower bound sets flag_o and status_o[channel] at the next rising clock edge. Equality counts as an event.
- R4: A value strictly between the two bounds changes neither flag_o nor status_o.
- R5: Only channels whose mask bit is 1 are tested. Address 4 holds mask bits 7..0 and address 5 holds mask bits 15..8. A result on a channel whose mask bit is 0 causes no event.
- R6: The upper bound is written as a pair. Address 1 stages bits 9..8 from write data bits 1..0. Address 0 supplies bits 7..0 and commits the whole bound. The lower bound works the same way at addresses 3 (upper bits) and 2 (low byte, commits). A write to an upper-bits address alone leaves the bound in force unchanged.
- R7: Status bits and the flag are sticky. Writing address 6 (channels 7..0) or address 7 (channels 15..8) clears each status bit whose data bit is 0 and leaves each bit whose data bit is 1. Writing address 8 with data bit 1 at 0 clears the flag. Data bit 1 at 1 leaves the flag unchanged.
- R8: irq_o is high exactly when the flag is set and the interrupt enable is set. The interrupt enable is bit 0 of address 8.
- R9: When an event and a clear of the same status bit or of the flag fall in the same cycle, the bit ends up set.
- R10: A result presented with res_valid_i low causes no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | Conversion result strobe |
| res_data_i | input | 10 | Conversion value |
| res_chan_i | input | 4 | Channel that produced the value |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address (0..8) |
| reg_wdata_i | input | 8 | Register write data |
| flag_o | output | 1 | Global sticky watchdog flag |
| status_o | output | 16 | Per-channel sticky event bits |
| irq_o | output | 1 | Watchdog interrupt |

## Verification
Two things can land on the same status bit or on the flag in one cycle: an event that sets it and a software write that clears it. The bench provokes this in directed steps. In one step, a result on an enabled channel arrives together with a status write of all zeros. In another, it arrives together with a control write that clears the flag. Each time, the bench expects the bit to end up set and every other cleared bit to end up cleared. Random steps then mix results and register writes in the same cycles. The outputs are checked after every edge against a model that applies the clears first and the set last.

// File: rtl/win_wdg_pkg.sv
package win_wdg_pkg;
  localparam logic [3:0] ADDR_HI_L  = 4'd0;
  localparam logic [3:0] ADDR_HI_H  = 4'd1;
  localparam logic [3:0] ADDR_LO_L  = 4'd2;
  localparam logic [3:0] ADDR_LO_H  = 4'd3;
  localparam logic [3:0] ADDR_MSK_L = 4'd4;
  localparam logic [3:0] ADDR_MSK_H = 4'd5;
  localparam logic [3:0] ADDR_ST_L  = 4'd6;
  localparam logic [3:0] ADDR_ST_H  = 4'd7;
  localparam logic [3:0] ADDR_CTRL  = 4'd8;
  localparam int CTRL_IE_BIT   = 0;
  localparam int CTRL_FLAG_BIT = 1;
endpackage

// File: rtl/win_wdg_cfg.sv
module win_wdg_cfg
  import win_wdg_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int NUM_CHAN = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [3:0]          addr_i,
  input  logic [7:0]          wdata_i,
  output logic [DATA_W-1:0]   thr_hi_o,
  output logic [DATA_W-1:0]   thr_lo_o,
  output logic [NUM_CHAN-1:0] mask_o,
  output logic                ie_o,
  output logic [NUM_CHAN-1:0] st_clr_o,
  output logic                flag_clr_o
);
  localparam int UP_W = DATA_W - 8;

  logic [DATA_W-1:0] thr_q [2];

  // t = 0: upper bound, t = 1: lower bound
  for (genvar t = 0; t < 2; t++) begin : g_thr
    localparam logic [3:0] A_LOW = 4'(2 * t);
    localparam logic [3:0] A_UP  = 4'(2 * t + 1);
    localparam logic [DATA_W-1:0] RST_V = (t == 0) ? {DATA_W{1'b1}} : '0;
    logic [UP_W-1:0] stage_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q  <= '0;
        thr_q[t] <= RST_V;
      end else if (we_i) begin
        if (addr_i == A_UP)  stage_q  <= wdata_i[UP_W-1:0];
        if (addr_i == A_LOW) thr_q[t] <= {stage_q, wdata_i};
      end
    end

    assert_thr_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && addr_i == A_LOW) |=> $stable(thr_q[t]));
  end

  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_chan
    localparam logic [3:0] A_MSK = ADDR_MSK_L + 4'(i / 8);
    localparam logic [3:0] A_ST  = ADDR_ST_L + 4'(i / 8);
    logic m_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     m_q <= 1'b0;
      else if (we_i && addr_i == A_MSK) m_q <= wdata_i[i % 8];
    end
    assign mask_o[i]   = m_q;
    assign st_clr_o[i] = we_i && addr_i == A_ST && !wdata_i[i % 8];
  end

  logic ie_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           ie_q <= 1'b0;
    else if (we_i && addr_i == ADDR_CTRL)  ie_q <= wdata_i[CTRL_IE_BIT];
  end

  assign ie_o       = ie_q;
  assign flag_clr_o = we_i && addr_i == ADDR_CTRL && !wdata_i[CTRL_FLAG_BIT];
  assign thr_hi_o   = thr_q[0];
  assign thr_lo_o   = thr_q[1];
endmodule

// File: rtl/win_wdg_cmp.sv
module win_wdg_cmp #(
  parameter int DATA_W   = 10,
  parameter int CHAN_W   = 4,
  parameter int NUM_CHAN = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic [CHAN_W-1:0]   chan_i,
  input  logic [DATA_W-1:0]   thr_hi_i,
  input  logic [DATA_W-1:0]   thr_lo_i,
  input  logic [NUM_CHAN-1:0] mask_i,
  output logic [NUM_CHAN-1:0] ev_o
);
  logic hit;
  assign hit = (data_i >= thr_hi_i) || (data_i <= thr_lo_i);

  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_ev
    assign ev_o[i] = valid_i && hit && mask_i[i] && (chan_i == CHAN_W'(i));
  end

  assert_ev_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ev_o));
  assert_ev_needs_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ev_o == '0);
endmodule

// File: rtl/win_wdg_sticky.sv
module win_wdg_sticky #(
  parameter int NUM_CHAN = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CHAN-1:0] set_i,
  input  logic [NUM_CHAN-1:0] clr_i,
  input  logic                flag_clr_i,
  output logic [NUM_CHAN-1:0] status_o,
  output logic                flag_o
);
  logic [NUM_CHAN-1:0] st_q;
  logic                flag_q;

  // set is applied after clear so a coincident event survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      st_q   <= (st_q & ~clr_i) | set_i;
      flag_q <= (flag_q & ~flag_clr_i) | (|set_i);
    end
  end

  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_chk
    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> st_q[i]);
    assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[i] && !clr_i[i]) |=> st_q[i]);
  end
  assert_flag_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> flag_q);

  assign status_o = st_q;
  assign flag_o   = flag_q;
endmodule

// File: rtl/win_wdg_top.sv
module win_wdg_top #(
  parameter int DATA_W = 10,
  parameter int CHAN_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    res_valid_i,
  input  logic [DATA_W-1:0]       res_data_i,
  input  logic [CHAN_W-1:0]       res_chan_i,
  input  logic                    reg_we_i,
  input  logic [3:0]              reg_addr_i,
  input  logic [7:0]              reg_wdata_i,
  output logic                    flag_o,
  output logic [(1<<CHAN_W)-1:0]  status_o,
  output logic                    irq_o
);
  localparam int NUM_CHAN = 1 << CHAN_W;

  logic [DATA_W-1:0]   thr_hi, thr_lo;
  logic [NUM_CHAN-1:0] mask, st_clr, ev;
  logic                ie, flag_clr;

  win_wdg_cfg #(.DATA_W(DATA_W), .NUM_CHAN(NUM_CHAN)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .thr_hi_o(thr_hi), .thr_lo_o(thr_lo), .mask_o(mask), .ie_o(ie),
    .st_clr_o(st_clr), .flag_clr_o(flag_clr)
  );

  win_wdg_cmp #(.DATA_W(DATA_W), .CHAN_W(CHAN_W), .NUM_CHAN(NUM_CHAN)) u_cmp (
    .clk_i, .rst_ni,
    .valid_i(res_valid_i), .data_i(res_data_i), .chan_i(res_chan_i),
    .thr_hi_i(thr_hi), .thr_lo_i(thr_lo), .mask_i(mask), .ev_o(ev)
  );

  win_wdg_sticky #(.NUM_CHAN(NUM_CHAN)) u_st (
    .clk_i, .rst_ni,
    .set_i(ev), .clr_i(st_clr), .flag_clr_i(flag_clr),
    .status_o(status_o), .flag_o(flag_o)
  );

  assign irq_o = flag_o && ie;

  assert_irq_needs_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o);
  assert_flag_rise_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(res_valid_i));
  for (genvar k = 0; k < NUM_CHAN; k++) begin : g_rise
    assert_rise_enabled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_o[k]) |-> $past(res_valid_i && res_chan_i == CHAN_W'(k) && mask[k]));
  end
endmodule

// File: tb/sim_win_wdg_top.sv
module sim_win_wdg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic [9:0]  res_data = '0;
  logic [3:0]  res_chan = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        flag;
  logic [15:0] status;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // reference state
  logic [9:0]  m_hi = 10'h3FF, m_lo = 10'h000;
  logic [1:0]  m_hs = '0, m_ls = '0;
  logic [15:0] m_mask = '0, m_st = '0;
  logic        m_ie = 1'b0, m_flag = 1'b0;

  always #4 clk = ~clk;

  win_wdg_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .res_valid_i(res_valid), .res_data_i(res_data), .res_chan_i(res_chan),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .flag_o(flag), .status_o(status), .irq_o(irq)
  );

  function automatic void model(input logic v, input logic [9:0] d, input logic [3:0] c,
                                input logic w, input logic [3:0] a, input logic [7:0] wd);
    logic        ev;
    logic [15:0] clr;
    logic        fclr;
    ev   = v && m_mask[c] && (d >= m_hi || d <= m_lo);
    clr  = '0;
    fclr = 1'b0;
    if (w) begin
      case (a)
        4'd0: m_hi = {m_hs, wd};
        4'd1: m_hs = wd[1:0];
        4'd2: m_lo = {m_ls, wd};
        4'd3: m_ls = wd[1:0];
        4'd4: m_mask[7:0]  = wd;
        4'd5: m_mask[15:8] = wd;
        4'd6: clr[7:0]  = ~wd;
        4'd7: clr[15:8] = ~wd;
        4'd8: begin m_ie = wd[0]; fclr = !wd[1]; end
        default: ;
      endcase
    end
    m_st   = (m_st & ~clr) | (ev ? (16'd1 << c) : 16'd0);
    m_flag = (m_flag & ~fclr) | ev;
  endfunction

  task automatic step(input logic v, input logic [9:0] d, input logic [3:0] c,
                      input logic w, input logic [3:0] a, input logic [7:0] wd);
    @(negedge clk);
    res_valid = v; res_data = d; res_chan = c;
    reg_we = w; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    #2;
    model(v, d, c, w, a, wd);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] wd);
    step(1'b0, 10'd0, 4'd0, 1'b1, a, wd);
  endtask

  task automatic res(input logic [9:0] d, input logic [3:0] c);
    step(1'b1, d, c, 1'b0, 4'd0, 8'd0);
  endtask

  task automatic check(input string tag);
    n_chk += 3;
    if (flag !== m_flag) begin
      n_err++; $display("FAIL %s flag_o got %0b exp %0b", tag, flag, m_flag);
    end
    if (status !== m_st) begin
      n_err++; $display("FAIL %s status_o got %h exp %h", tag, status, m_st);
    end
    if (irq !== (m_flag && m_ie)) begin
      n_err++; $display("FAIL %s irq_o got %0b exp %0b", tag, irq, m_flag && m_ie);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #20 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset");

    wr(4'd4, 8'h08);               check("R5 enable ch3");
    wr(4'd1, 8'h02);               check("R6 upper only");
    res(10'h2FF, 4'd3);            check("R6 bound not committed");
    wr(4'd0, 8'h00);               check("R6 commit hi=0x200");
    res(10'h1FF, 4'd3);            check("R4 between");
    res(10'h200, 4'd3);            check("R2 equal upper");
    wr(4'd6, 8'hF7);               check("R7 clear status bit3");
    res(10'h100, 4'd3);            check("R7 flag sticky, between");
    wr(4'd8, 8'h00);               check("R7 clear flag");
    wr(4'd3, 8'h00);
    wr(4'd2, 8'h40);               check("R6 commit lo=0x40");
    res(10'h040, 4'd3);            check("R3 equal lower");
    res(10'h3FF, 4'd5);            check("R5 masked ch5");
    wr(4'd6, 8'h00); wr(4'd8, 8'h00);
    step(1'b0, 10'h3FF, 4'd3, 1'b0, 4'd0, 8'd0); check("R10 valid low");
    wr(4'd5, 8'h10);
    res(10'h3FF, 4'd12);           check("R5 enable ch12 via upper mask");
    wr(4'd7, 8'hEF);               check("R7 clear status bit12");
    wr(4'd8, 8'h03);               check("R8 ie set, flag kept");
    wr(4'd8, 8'h01);               check("R8 flag cleared");
    res(10'h001, 4'd3);            check("R8 irq raised");
    step(1'b1, 10'h3FF, 4'd3, 1'b1, 4'd6, 8'h00); check("R9 status clear vs event");
    step(1'b1, 10'h3FF, 4'd3, 1'b1, 4'd8, 8'h01); check("R9 flag clear vs event");
    wr(4'd6, 8'h00); wr(4'd7, 8'h00); wr(4'd8, 8'h00);
    check("R7 all cleared");

    for (int n = 0; n < 4000; n++) begin
      logic [9:0] d;
      logic [3:0] a;
      case ($urandom % 4)
        0: d = m_hi + 10'($urandom % 3) - 10'd1;
        1: d = m_lo + 10'($urandom % 3) - 10'd1;
        default: d = 10'($urandom);
      endcase
      a = 4'($urandom % 9);
      step(1'($urandom), d, 4'($urandom), ($urandom % 3) == 0, a, 8'($urandom));
      check("R2 R3 R7 R9 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule